// File: doc/BRIEF.md
# LFSR Raster Timing Generator

This block produces the raster timing for a display pipe: a horizontal sync, a vertical sync, a data-enable that frames the visible area, and one-cycle pulses that mark the start of every line and of every frame. It runs on the pixel clock. It uses no binary position counters. Both the pixel position within a line and the line position within a frame are 16-bit Fibonacci LFSRs, which keeps the next-state logic to a shift and one four-input XOR. Every limit is an equality compare against an LFSR state.

Software never hands the block a plain count. Each limit arrives already encoded as the LFSR state reached after the wanted number of steps from the all-ones seed. The register decoder presents a full set of encoded limits and pulses `commit`. The block stages that set and switches to it only at the next frame boundary, so a frame never mixes two timings. The output-mode input selects normal output, blanking (data-enable held low while the syncs keep running) or power-down (syncs and data-enable held low). The mode acts immediately.

The encoding rules software must follow are these:
- The horizontal wrap code is the state for the total line length minus one.
- The vertical wrap code is the state for the total line count.
- The horizontal sync codes are step 1 and step (pulse width + 1).
- The vertical sync codes are step 0 and step (pulse width).
- In each axis, the visible window opens at (total − sync start position) and closes at that value plus the visible length.

Top module: `lfsr_raster_timer`

## Requirements
- R1: The pixel position starts at 16'hFFFF and advances once per clock to {p[14:0], p[15]^p[4]^p[2]^p[1]}. It reloads 16'hFFFF in the cycle after it equals `hEndCode`. A line whose wrap code is the state for step N therefore lasts N+1 clocks.
- R2: The line position advances by the same rule once per line. When the advance would reach `vEndCode`, it reloads 16'hFFFF instead. A frame whose vertical code is the state for step V therefore has exactly V lines.
- R3: Pixel step 0 of a line makes `lineStart` high in the following cycle. `hSync` goes high when the step matches `hSyncOnCode` and low when it matches `hSyncOffCode`, each with the same one-cycle delay. With codes for steps 1 and W+1, `hSync` rises one clock after `lineStart` and stays high for W clocks.
- R4: `vSync` goes high on the line whose position matches `vSyncOnCode` and low on the line matching `vSyncOffCode`. It changes in the same cycle as that line's `lineStart`. With codes for steps 0 and W, it is high for W lines and is high during `frameStart`.
- R5: `dataEn` is high only where two windows overlap. The pixel window runs from `hActOnCode` up to, but not including, `hActOffCode`. The line window runs the same way from `vActOnCode` to `vActOffCode`.
- R6: `lineStart` is a one-cycle pulse at pixel step 0 of every line. `frameStart` is a one-cycle pulse at pixel step 0 of line step 0, and it is always accompanied by `lineStart`.
- R7: `commit` captures all ten limit inputs. The captured set takes effect at the next frame boundary, so the current frame finishes on the old limits. If several commits arrive before that boundary, the last one wins. Limit inputs that change without `commit` have no effect.
- R8: `outMode` 2'b00 gives normal output. 2'b01 holds `dataEn` low while the syncs run. 2'b10 and 2'b11 hold `hSync`, `vSync` and `dataEn` low. In every mode `lineStart` and `frameStart` keep running, and a mode change reaches the outputs one clock later.
- R9: While `rstN` is low, all outputs are low. The limits return to the values set by the top-level parameters. The first `frameStart` appears two clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| outMode | input | 2 | 00 normal, 01 blank, 1x power-down |
| commit | input | 1 | Capture the limit inputs for the next frame |
| hEndCode | input | 16 | LFSR state of the last pixel step of a line |
| hSyncOnCode | input | 16 | Pixel step at which hSync rises |
| hSyncOffCode | input | 16 | Pixel step at which hSync falls |
| hActOnCode | input | 16 | First visible pixel step |
| hActOffCode | input | 16 | First pixel step past the visible area |
| vEndCode | input | 16 | Line step that wraps the frame |
| vSyncOnCode | input | 16 | Line step at which vSync rises |
| vSyncOffCode | input | 16 | Line step at which vSync falls |
| vActOnCode | input | 16 | First visible line step |
| vActOffCode | input | 16 | First line step past the visible area |
| hSync | output | 1 | Horizontal sync, active high |
| vSync | output | 1 | Vertical sync, active high |
| dataEn | output | 1 | Visible-area enable |
| lineStart | output | 1 | One-cycle pulse at the start of each line |
| frameStart | output | 1 | One-cycle pulse at the start of each frame |

## Verification
Every output lags the position registers by exactly one clock. The bench therefore measures each result relative to the `lineStart` pulse of its own line, not to absolute time. Expected values follow directly from the pulse offsets above:
- `hSync` rises one clock after `lineStart`.
- `vSync` changes together with `lineStart`.
- The data-enable window starts (total − sync start) clocks into the line.

A `commit` lands only at the next frame boundary, and a mode change lands one clock later. For that reason the bench never scores the frame in which it makes a change. Expected records are tagged with the index of the first whole frame after the change, and the monitor compares a record only when that frame completes.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int LFSR_W = 16;

  typedef logic [LFSR_W-1:0] lfsr_t;

  localparam lfsr_t LFSR_SEED = '1;

  // Encoded limits in force for one frame
  typedef struct packed {
    lfsr_t hEnd;
    lfsr_t hsOn;
    lfsr_t hsOff;
    lfsr_t hdOn;
    lfsr_t hdOff;
    lfsr_t vEnd;
    lfsr_t vsOn;
    lfsr_t vsOff;
    lfsr_t vdOn;
    lfsr_t vdOff;
  } timing_cfg_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic lineWrap;
    logic frameWrap;
    logic primeCycle;
  } seq_strobe_t;

  // Datapath -> control match results
  typedef struct packed {
    logic hEndHit;
    logic vEndHit;
  } pos_hits_t;

  typedef enum logic [1:0] {
    MODE_ON    = 2'b00,
    MODE_BLANK = 2'b01,
    MODE_OFF_A = 2'b10,
    MODE_OFF_B = 2'b11
  } out_mode_e;

  function automatic lfsr_t lfsrAdvance(input lfsr_t s);
    return {s[LFSR_W-2:0], s[15] ^ s[4] ^ s[2] ^ s[1]};
  endfunction

  function automatic lfsr_t lfsrEncode(input int steps);
    lfsr_t s;
    s = LFSR_SEED;
    for (int i = 0; i < steps; i++) s = lfsrAdvance(s);
    return s;
  endfunction

endpackage

// File: rtl/raster_seq_ctrl.sv
module raster_seq_ctrl
  import raster_pkg::*;
#(
  parameter timing_cfg_t RESET_CFG = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        commit,
  input  timing_cfg_t cfgIn,
  input  pos_hits_t   hits,
  output seq_strobe_t strb,
  output timing_cfg_t cfgLive
);

  logic        primeR;
  logic        pendingR;
  timing_cfg_t stageR;
  logic        applyCfg;

  always_comb begin
    strb.primeCycle = primeR;
    strb.lineWrap   = primeR | hits.hEndHit;
    strb.frameWrap  = primeR | (hits.hEndHit & hits.vEndHit);
    applyCfg        = strb.frameWrap & pendingR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primeR   <= 1'b1;
      pendingR <= 1'b0;
      stageR   <= RESET_CFG;
      cfgLive  <= RESET_CFG;
    end else begin
      primeR <= 1'b0;
      if (applyCfg) cfgLive <= stageR;
      if (commit) begin
        stageR   <= cfgIn;
        pendingR <= 1'b1;
      end else if (strb.frameWrap) begin
        pendingR <= 1'b0;
      end
    end
  end

  // R7
  property cfg_hold_p;
    @(posedge clk) disable iff (!rstN) !applyCfg |=> $stable(cfgLive);
  endproperty
  cfg_hold_chk: assert property (cfg_hold_p);

  // R6
  property frame_in_line_p;
    @(posedge clk) disable iff (!rstN) strb.frameWrap |-> strb.lineWrap;
  endproperty
  frame_in_line_chk: assert property (frame_in_line_p);

endmodule

// File: rtl/raster_pos_dpath.sv
module raster_pos_dpath
  import raster_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seq_strobe_t strb,
  input  timing_cfg_t cfg,
  input  logic [1:0]  outMode,
  output pos_hits_t   hits,
  output logic        hSync,
  output logic        vSync,
  output logic        dataEn,
  output logic        lineStart,
  output logic        frameStart
);

  lfsr_t hPos, vPos, hStep, vStep, vLoad;
  logic  hsR, hdR, vsR, vdR;
  logic  hsNext, hdNext, vsNext, vdNext;
  logic  powerDown, normalOut;

  always_comb begin
    hStep        = lfsrAdvance(hPos);
    vStep        = lfsrAdvance(vPos);
    vLoad        = strb.frameWrap ? LFSR_SEED : vStep;
    hits.hEndHit = (hPos == cfg.hEnd);
    hits.vEndHit = (vStep == cfg.vEnd);

    hsNext = (hPos == cfg.hsOn) ? 1'b1 : (hPos == cfg.hsOff) ? 1'b0 : hsR;
    hdNext = (hPos == cfg.hdOn) ? 1'b1 : (hPos == cfg.hdOff) ? 1'b0 : hdR;
    vsNext = (vLoad == cfg.vsOn) ? 1'b1 : (vLoad == cfg.vsOff) ? 1'b0 : vsR;
    vdNext = (vLoad == cfg.vdOn) ? 1'b1 : (vLoad == cfg.vdOff) ? 1'b0 : vdR;

    powerDown = outMode[1];
    normalOut = (outMode == MODE_ON);
  end

  // Position registers and window flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hPos <= LFSR_SEED;
      vPos <= LFSR_SEED;
      hsR  <= 1'b0;
      hdR  <= 1'b0;
      vsR  <= 1'b0;
      vdR  <= 1'b0;
    end else begin
      hPos <= strb.lineWrap ? LFSR_SEED : hStep;
      hsR  <= hsNext;
      hdR  <= hdNext;
      if (strb.lineWrap) begin
        vPos <= vLoad;
        vsR  <= vsNext;
        vdR  <= vdNext;
      end
    end
  end

  // Output stage: one clock behind the position registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hSync      <= 1'b0;
      vSync      <= 1'b0;
      dataEn     <= 1'b0;
      lineStart  <= 1'b0;
      frameStart <= 1'b0;
    end else begin
      hSync      <= hsNext & ~powerDown & ~strb.primeCycle;
      vSync      <= vsR & ~powerDown & ~strb.primeCycle;
      dataEn     <= hdNext & vdR & normalOut & ~strb.primeCycle;
      lineStart  <= (hPos == LFSR_SEED) & ~strb.primeCycle;
      frameStart <= (hPos == LFSR_SEED) & (vPos == LFSR_SEED) & ~strb.primeCycle;
    end
  end

  // R1
  property h_nonzero_p;
    @(posedge clk) disable iff (!rstN) hPos != '0;
  endproperty
  h_nonzero_chk: assert property (h_nonzero_p);

  // R6
  property frame_with_line_p;
    @(posedge clk) disable iff (!rstN) frameStart |-> lineStart;
  endproperty
  frame_with_line_chk: assert property (frame_with_line_p);

  // R6
  property line_pulse_p;
    @(posedge clk) disable iff (!rstN) lineStart |=> !lineStart;
  endproperty
  line_pulse_chk: assert property (line_pulse_p);

  // R8
  property pd_quiet_p;
    @(posedge clk) disable iff (!rstN) $past(outMode[1]) |-> (!hSync && !vSync && !dataEn);
  endproperty
  pd_quiet_chk: assert property (pd_quiet_p);

  // R8
  property blank_nodata_p;
    @(posedge clk) disable iff (!rstN) ($past(outMode) == 2'b01) |-> !dataEn;
  endproperty
  blank_nodata_chk: assert property (blank_nodata_p);

endmodule

// File: rtl/lfsr_raster_timer.sv
module lfsr_raster_timer
  import raster_pkg::*;
#(
  parameter int H_TOTAL      = 800,
  parameter int H_ACTIVE     = 640,
  parameter int H_SYNC_START = 656,
  parameter int H_SYNC_END   = 752,
  parameter int V_TOTAL      = 525,
  parameter int V_ACTIVE     = 480,
  parameter int V_SYNC_START = 490,
  parameter int V_SYNC_END   = 492
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  outMode,
  input  logic        commit,
  input  logic [15:0] hEndCode,
  input  logic [15:0] hSyncOnCode,
  input  logic [15:0] hSyncOffCode,
  input  logic [15:0] hActOnCode,
  input  logic [15:0] hActOffCode,
  input  logic [15:0] vEndCode,
  input  logic [15:0] vSyncOnCode,
  input  logic [15:0] vSyncOffCode,
  input  logic [15:0] vActOnCode,
  input  logic [15:0] vActOffCode,
  output logic        hSync,
  output logic        vSync,
  output logic        dataEn,
  output logic        lineStart,
  output logic        frameStart
);

  localparam int H_ACT_FIRST = H_TOTAL - H_SYNC_START;
  localparam int V_ACT_FIRST = V_TOTAL - V_SYNC_START;

  localparam timing_cfg_t RESET_CFG = '{
    hEnd:  lfsrEncode(H_TOTAL - 1),
    hsOn:  lfsrEncode(1),
    hsOff: lfsrEncode(H_SYNC_END - H_SYNC_START + 1),
    hdOn:  lfsrEncode(H_ACT_FIRST),
    hdOff: lfsrEncode(H_ACT_FIRST + H_ACTIVE),
    vEnd:  lfsrEncode(V_TOTAL),
    vsOn:  lfsrEncode(0),
    vsOff: lfsrEncode(V_SYNC_END - V_SYNC_START),
    vdOn:  lfsrEncode(V_ACT_FIRST),
    vdOff: lfsrEncode(V_ACT_FIRST + V_ACTIVE)
  };

  timing_cfg_t cfgIn, cfgLive;
  seq_strobe_t strb;
  pos_hits_t   hits;

  assign cfgIn = '{
    hEnd:  hEndCode,
    hsOn:  hSyncOnCode,
    hsOff: hSyncOffCode,
    hdOn:  hActOnCode,
    hdOff: hActOffCode,
    vEnd:  vEndCode,
    vsOn:  vSyncOnCode,
    vsOff: vSyncOffCode,
    vdOn:  vActOnCode,
    vdOff: vActOffCode
  };

  raster_seq_ctrl #(.RESET_CFG(RESET_CFG)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .commit  (commit),
    .cfgIn   (cfgIn),
    .hits    (hits),
    .strb    (strb),
    .cfgLive (cfgLive)
  );

  raster_pos_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .cfg        (cfgLive),
    .outMode    (outMode),
    .hits       (hits),
    .hSync      (hSync),
    .vSync      (vSync),
    .dataEn     (dataEn),
    .lineStart  (lineStart),
    .frameStart (frameStart)
  );

endmodule

// File: tb/lfsr_raster_timer_tb.sv
module lfsr_raster_timer_tb_top;

  typedef struct {
    int ht; int ha; int hss; int hse;
    int vt; int va; int vss; int vse;
  } mode_t;

  typedef struct {
    int    idx;
    string tag;
    int cycles; int lines; int lenMin; int lenMax;
    int hsCycles; int hsOffset; int vsLines; int vsAtStart;
    int deCycles; int deLines; int firstDeLine; int firstDeCol;
  } frame_rec_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  outMode = 2'b00;
  logic        commit = 1'b0;
  logic [15:0] hEndCode = '0, hSyncOnCode = '0, hSyncOffCode = '0, hActOnCode = '0, hActOffCode = '0;
  logic [15:0] vEndCode = '0, vSyncOnCode = '0, vSyncOffCode = '0, vActOnCode = '0, vActOffCode = '0;
  logic        hSync, vSync, dataEn, lineStart, frameStart;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  frame_rec_t expQ[$];

  localparam mode_t MODE_A = '{ht:32, ha:20, hss:24, hse:28, vt:12, va:8,  vss:9,  vse:11};
  localparam mode_t MODE_B = '{ht:40, ha:24, hss:30, hse:36, vt:16, va:10, vss:12, vse:15};
  localparam mode_t MODE_J = '{ht:50, ha:30, hss:35, hse:40, vt:20, va:12, vss:14, vse:16};

  always #10 clk = ~clk;

  lfsr_raster_timer #(
    .H_TOTAL(32), .H_ACTIVE(20), .H_SYNC_START(24), .H_SYNC_END(28),
    .V_TOTAL(12), .V_ACTIVE(8),  .V_SYNC_START(9),  .V_SYNC_END(11)
  ) dut_i (
    .clk(clk), .rstN(rstN), .outMode(outMode), .commit(commit),
    .hEndCode(hEndCode), .hSyncOnCode(hSyncOnCode), .hSyncOffCode(hSyncOffCode),
    .hActOnCode(hActOnCode), .hActOffCode(hActOffCode),
    .vEndCode(vEndCode), .vSyncOnCode(vSyncOnCode), .vSyncOffCode(vSyncOffCode),
    .vActOnCode(vActOnCode), .vActOffCode(vActOffCode),
    .hSync(hSync), .vSync(vSync), .dataEn(dataEn), .lineStart(lineStart), .frameStart(frameStart)
  );

  // Bench-side encoder: taps 15,4,2,1 as a mask
  function automatic logic [15:0] enc(input int steps);
    logic [15:0] s;
    s = 16'hFFFF;
    for (int k = 0; k < steps; k++) s = {s[14:0], ^(s & 16'h8016)};
    return s;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic frame_rec_t makeExp(input int idx, input mode_t m, input logic [1:0] om, input string tag);
    frame_rec_t e;
    bit pd, on;
    pd = om[1];
    on = (om == 2'b00);
    e.idx = idx;
    e.tag = tag;
    e.cycles = m.ht * m.vt;
    e.lines = m.vt;
    e.lenMin = m.ht;
    e.lenMax = m.ht;
    e.hsCycles = pd ? 0 : (m.hse - m.hss) * m.vt;
    e.hsOffset = pd ? -1 : 1;
    e.vsLines = pd ? 0 : (m.vse - m.vss);
    e.vsAtStart = pd ? 0 : 1;
    e.deCycles = on ? m.ha * m.va : 0;
    e.deLines = on ? m.va : 0;
    e.firstDeLine = on ? (m.vt - m.vss) : -1;
    e.firstDeCol = on ? (m.ht - m.hss) : -1;
    return e;
  endfunction

  // Driver: present encoded limits and pulse commit
  task automatic driveCodes(input mode_t m, input bit doCommit);
    @(negedge clk);
    hEndCode     = enc(m.ht - 1);
    hSyncOnCode  = enc(1);
    hSyncOffCode = enc(m.hse - m.hss + 1);
    hActOnCode   = enc(m.ht - m.hss);
    hActOffCode  = enc(m.ht - m.hss + m.ha);
    vEndCode     = enc(m.vt);
    vSyncOnCode  = enc(0);
    vSyncOffCode = enc(m.vse - m.vss);
    vActOnCode   = enc(m.vt - m.vss);
    vActOffCode  = enc(m.vt - m.vss + m.va);
    commit = doCommit;
    @(negedge clk);
    commit = 1'b0;
  endtask

  // Monitor state
  int frameCnt = 0;
  bit inFrame = 0, inLine = 0, lineHadDe = 0, prevHs = 0;
  int lineCyc = 0, lineIdx = 0;
  frame_rec_t acc;

  task automatic closeFrame();
    frame_rec_t e;
    while (expQ.size() > 0 && expQ[0].idx < frameCnt) begin
      e = expQ.pop_front();
      chk("R7", "expected frame never scored", 0, 1);
    end
    if (expQ.size() > 0 && expQ[0].idx == frameCnt) begin
      e = expQ.pop_front();
      chk({"R2 ", e.tag}, "frame cycles", acc.cycles, e.cycles);
      chk({"R2 ", e.tag}, "lines per frame", acc.lines, e.lines);
      chk({"R1 ", e.tag}, "shortest line", acc.lenMin, e.lenMin);
      chk({"R1 ", e.tag}, "longest line", acc.lenMax, e.lenMax);
      chk({"R3 ", e.tag}, "hSync cycles", acc.hsCycles, e.hsCycles);
      chk({"R3 ", e.tag}, "hSync rise offset", acc.hsOffset, e.hsOffset);
      chk({"R4 ", e.tag}, "vSync lines", acc.vsLines, e.vsLines);
      chk({"R4 ", e.tag}, "vSync at frameStart", acc.vsAtStart, e.vsAtStart);
      chk({"R5 ", e.tag}, "dataEn cycles", acc.deCycles, e.deCycles);
      chk({"R5 ", e.tag}, "dataEn lines", acc.deLines, e.deLines);
      chk({"R5 ", e.tag}, "first visible line", acc.firstDeLine, e.firstDeLine);
      chk({"R5 ", e.tag}, "first visible column", acc.firstDeCol, e.firstDeCol);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      if (lineStart && inLine) begin
        if (lineCyc < acc.lenMin) acc.lenMin = lineCyc;
        if (lineCyc > acc.lenMax) acc.lenMax = lineCyc;
      end
      if (frameStart) begin
        chk("R6", "lineStart with frameStart", int'(lineStart), 1);
        if (inFrame) closeFrame();
        frameCnt++;
        inFrame = 1;
        acc = '{idx:frameCnt, tag:"", cycles:0, lines:0, lenMin:1000000, lenMax:0,
                hsCycles:0, hsOffset:-1, vsLines:0, vsAtStart:int'(vSync),
                deCycles:0, deLines:0, firstDeLine:-1, firstDeCol:-1};
      end
      if (lineStart) begin
        lineCyc = 0;
        lineIdx = acc.lines;
        acc.lines++;
        lineHadDe = 0;
        inLine = 1;
        if (vSync) acc.vsLines++;
      end
      if (inFrame) begin
        acc.cycles++;
        if (hSync) begin
          acc.hsCycles++;
          if (!prevHs) acc.hsOffset = lineCyc;
        end
        if (dataEn) begin
          acc.deCycles++;
          if (!lineHadDe) begin
            lineHadDe = 1;
            acc.deLines++;
            if (acc.firstDeLine < 0) begin
              acc.firstDeLine = lineIdx;
              acc.firstDeCol = lineCyc;
            end
          end
        end
      end
      lineCyc++;
      prevHs = hSync;
    end
  end

  task automatic waitFrame(input int n);
    while (frameCnt < n) @(negedge clk);
    repeat (50) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    // R9: the first two frames run on the parameter defaults (mode A)
    expQ.push_back(makeExp(1, MODE_A, 2'b00, "R9"));
    expQ.push_back(makeExp(2, MODE_A, 2'b00, "R7"));
    repeat (4) @(negedge clk);
    chk("R9", "hSync in reset", int'(hSync), 0);
    chk("R9", "vSync in reset", int'(vSync), 0);
    chk("R9", "dataEn in reset", int'(dataEn), 0);
    chk("R9", "frameStart in reset", int'(frameStart), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "frameStart one clock after release", int'(frameStart), 0);
    @(negedge clk);
    chk("R9", "frameStart two clocks after release", int'(frameStart), 1);
    chk("R6", "lineStart on first frame", int'(lineStart), 1);

    // R7: commit mid-frame 2; frame 2 stays on mode A, frame 3 on mode B
    waitFrame(2);
    driveCodes(MODE_B, 1'b1);
    expQ.push_back(makeExp(3, MODE_B, 2'b00, "R7"));

    // R8: blanking set in unscored frame 4, scored in frame 5
    waitFrame(4);
    outMode = 2'b01;
    expQ.push_back(makeExp(5, MODE_B, 2'b01, "R8"));

    // R8: power-down set in frame 6, scored in frame 7
    waitFrame(6);
    outMode = 2'b11;
    expQ.push_back(makeExp(7, MODE_B, 2'b11, "R8"));

    // R8: back to normal in frame 8, scored in frame 9
    waitFrame(8);
    outMode = 2'b00;
    expQ.push_back(makeExp(9, MODE_B, 2'b00, "R8"));

    // R7: two commits in frame 9 (last wins), then codes change without commit
    waitFrame(9);
    driveCodes(MODE_J, 1'b1);
    driveCodes(MODE_A, 1'b1);
    driveCodes(MODE_J, 1'b0);
    expQ.push_back(makeExp(10, MODE_A, 2'b00, "R7"));

    waitFrame(11);
    chk("R7", "expected frames left unscored", expQ.size(), 0);
    finishRun();
  end

endmodule